// File: doc/BRIEF.md
# Interrupt Request Arbiter with Fixed or Round-Robin Priority

The block merges a set of peripheral interrupt request lines into a single processor interrupt. When the processor answers with its acknowledge, the block picks one of the requesters and raises that peripheral's grant line. The granted peripheral then drives its vector onto the processor's data bus, which is outside this block. The grant stays on that peripheral until the processor drops its acknowledge, which marks the end of servicing.

A one-bit mode register selects how the winner is chosen. In fixed mode the lowest index always wins. In round-robin mode the search starts at a rotation pointer, and the pointer moves past whichever peripheral was served last. The mode register is written through a single-cycle configuration strobe and plays no other part in transfers.

The controller has three named states. In `S_IDLE` it waits for an acknowledge. From there the transition *ack with request* goes to `S_SERVE` and latches the winner, and the transition *ack without request* goes to `S_EMPTY`. From `S_SERVE` the transition *release* goes back to `S_IDLE` when the acknowledge falls, and in round-robin mode it advances the pointer. From `S_EMPTY` the transition *release* goes back to `S_IDLE` when the acknowledge falls and changes nothing.

Top module: `irq_arbiter`

## Requirements
- R1: `irq_o` is high in the same cycle as any bit of `req_i` is high, and low when all bits of `req_i` are low.
- R2: If `req_i` is nonzero on the first clock edge at which `cpu_ack_i` is seen high, then from the next cycle on, for as long as `cpu_ack_i` stays high, exactly one bit of `grant_o` is high. That bit is one whose request was set at that edge.
- R3: In fixed mode (mode bit 0), the lowest set index of `req_i` wins, so bit 0 has the highest rank.
- R4: In round-robin mode (mode bit 1), the search starts at the rotation pointer and goes upward with wrap-around. The pointer resets to 0. When a grant is released in round-robin mode, the pointer becomes the winner index plus 1, modulo the number of requesters, so the peripheral just served has the lowest rank.
- R5: The grant stays on the same peripheral while `cpu_ack_i` stays high, whatever `req_i` does. All `grant_o` bits drop in the same cycle that `cpu_ack_i` goes low.
- R6: An acknowledge that finds `req_i` all zero produces no grant for its whole duration, even if requests arrive while it is still high.
- R7: A cycle with `cfg_we_i` high loads `cfg_rotate_i` into the mode bit, and the mode bit resets to 0. A grant released in fixed mode leaves the rotation pointer unchanged.
- R8: Only one arbitration takes place per acknowledge. A new winner is chosen only after `cpu_ack_i` has been seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_REQ | Peripheral interrupt requests |
| cpu_ack_i | input | 1 | Processor interrupt acknowledge, high while servicing |
| cfg_we_i | input | 1 | Configuration write strobe for the mode bit |
| cfg_rotate_i | input | 1 | Mode bit value to write: 0 for fixed, 1 for round-robin |
| irq_o | output | 1 | Interrupt to the processor |
| grant_o | output | N_REQ | Per-peripheral acknowledge, at most one bit high |

## Verification
The bench builds the block with the default of four requesters. This is small enough that the rotation pointer can be walked all the way round and made to wrap from index 3 back to 0 within a few acknowledges. Four requesters also allow request patterns with holes, such as 1001 and 1101. With these patterns, starting the search at the pointer gives a different winner from taking the lowest set index, so the two modes and a stale or reset pointer give visibly different grants.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SERVE = 2'd1,
        S_EMPTY = 2'd2
    } arb_state_t;
endpackage

// File: rtl/irq_arb_pick.sv
module irq_arb_pick #(
    parameter int N_REQ = 4,
    parameter int IDX_W = 2
) (
    input  logic [N_REQ-1:0] req_i,
    input  logic [IDX_W-1:0] base_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);
    // Scan upward from base_i with wrap-around; the first set request wins.
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int k = 0; k < N_REQ; k++) begin
            int p;
            p = (int'(base_i) + k) % N_REQ;
            if (!valid_o && req_i[p]) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(p);
            end
        end
    end
endmodule

// File: rtl/irq_arb_ctrl.sv
module irq_arb_ctrl
    import irq_arb_pkg::*;
#(
    parameter int N_REQ = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_ack_i,
    input  logic             pick_valid_i,
    input  logic [IDX_W-1:0] pick_idx_i,
    input  logic             rotate_i,
    output logic [IDX_W-1:0] ptr_o,
    output arb_state_t       state_o,
    output logic [N_REQ-1:0] grant_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_REQ - 1);

    arb_state_t       state_q, state_d;
    logic [IDX_W-1:0] win_q;
    logic [IDX_W-1:0] ptr_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (cpu_ack_i) state_d = pick_valid_i ? S_SERVE : S_EMPTY;
            S_SERVE: if (!cpu_ack_i) state_d = S_IDLE;
            S_EMPTY: if (!cpu_ack_i) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Winner latch and rotation pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
            ptr_q <= '0;
        end else begin
            if (state_q == S_IDLE && cpu_ack_i && pick_valid_i)
                win_q <= pick_idx_i;
            if (state_q == S_SERVE && !cpu_ack_i && rotate_i)
                ptr_q <= (win_q == LAST_IDX) ? '0 : win_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        grant_o = '0;
        if (state_q == S_SERVE && cpu_ack_i)
            grant_o[win_q] = 1'b1;
    end

    assign ptr_o   = ptr_q;
    assign state_o = state_q;

    AST_HOLD_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0 && cpu_ack_i) |=> (!cpu_ack_i || $stable(grant_o))); // R5
    AST_ACK_LOW_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ack_i |-> grant_o == '0); // R8
    AST_EMPTY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && cpu_ack_i && !pick_valid_i) |=> grant_o == '0); // R6
    AST_ROTATE_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SERVE && !cpu_ack_i && rotate_i) |=> ptr_q != $past(win_q)); // R4
    AST_FIXED_PTR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !rotate_i |=> $stable(ptr_q)); // R7
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int N_REQ = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req_i,
    input  logic             cpu_ack_i,
    input  logic             cfg_we_i,
    input  logic             cfg_rotate_i,
    output logic             irq_o,
    output logic [N_REQ-1:0] grant_o
);
    localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;

    logic             rotate_q;
    logic [IDX_W-1:0] ptr;
    logic [IDX_W-1:0] base;
    logic             pick_valid;
    logic [IDX_W-1:0] pick_idx;
    arb_state_t       state;

    // Mode bit, loaded by the configuration strobe
    always_ff @(posedge clk) begin
        if (!rst_n)        rotate_q <= 1'b0;
        else if (cfg_we_i) rotate_q <= cfg_rotate_i;
    end

    assign irq_o = |req_i;
    assign base  = rotate_q ? ptr : '0;

    irq_arb_pick #(.N_REQ(N_REQ), .IDX_W(IDX_W)) u_pick (
        .req_i   (req_i),
        .base_i  (base),
        .valid_o (pick_valid),
        .idx_o   (pick_idx)
    );

    irq_arb_ctrl #(.N_REQ(N_REQ), .IDX_W(IDX_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_ack_i    (cpu_ack_i),
        .pick_valid_i (pick_valid),
        .pick_idx_i   (pick_idx),
        .rotate_i     (rotate_q),
        .ptr_o        (ptr),
        .state_o      (state),
        .grant_o      (grant_o)
    );

    AST_GRANT_TO_REQUESTER: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && cpu_ack_i && req_i != '0) |=>
        (!cpu_ack_i || ($countones(grant_o) == 1 && (grant_o & $past(req_i)) != '0))); // R2
    AST_FIXED_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && cpu_ack_i && !rotate_q && req_i[0]) |=>
        (!cpu_ack_i || grant_o[0])); // R3
    AST_IRQ_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i != '0) |-> irq_o); // R1
endmodule

// File: tb/irq_arbiter_test.sv
`timescale 1ns/1ps
module irq_arbiter_test;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req_i = '0;
    logic         cpu_ack_i = 1'b0;
    logic         cfg_we_i = 1'b0;
    logic         cfg_rotate_i = 1'b0;
    logic         irq_o;
    logic [N-1:0] grant_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_arbiter #(.N_REQ(N)) uut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .cpu_ack_i(cpu_ack_i),
        .cfg_we_i(cfg_we_i), .cfg_rotate_i(cfg_rotate_i),
        .irq_o(irq_o), .grant_o(grant_o)
    );

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_i = '0; cpu_ack_i = 1'b0; cfg_we_i = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_mode(input logic rot);
        cfg_we_i = 1'b1; cfg_rotate_i = rot;
        @(negedge clk);
        cfg_we_i = 1'b0;
        @(negedge clk);
    endtask

    // One acknowledge cycle: raise ack, check the grant one edge later, release.
    task automatic serve(input string tag, input logic [N-1:0] rq, input logic [N-1:0] exp);
        req_i = rq;
        cpu_ack_i = 1'b1;
        @(negedge clk);
        check(tag, grant_o, exp);
        cpu_ack_i = 1'b0;
        #1;
        check({tag, " release R5"}, grant_o, '0);
        @(negedge clk);
        req_i = '0;
        @(negedge clk);
    endtask

    task automatic t_reset_irq();
        check("R1 reset irq", {3'b0, irq_o}, '0);
        check("R2 reset grant", grant_o, '0);
        req_i = 4'b0100; #1;
        check("R1 irq on request", {3'b0, irq_o}, 4'b0001);
        req_i = '0; #1;
        check("R1 irq off", {3'b0, irq_o}, '0);
        @(negedge clk);
    endtask

    task automatic t_fixed();
        serve("R3 fixed 1010", 4'b1010, 4'b0010);
        serve("R3 fixed 1111", 4'b1111, 4'b0001);
        serve("R7 fixed no rotate 1111", 4'b1111, 4'b0001);
        serve("R3 fixed 1000", 4'b1000, 4'b1000);
    endtask

    task automatic t_hold();
        req_i = 4'b0110; cpu_ack_i = 1'b1;
        @(negedge clk);
        check("R2 hold first", grant_o, 4'b0010);
        req_i = 4'b1001;
        @(negedge clk); @(negedge clk);
        check("R5 hold after request change", grant_o, 4'b0010);
        check("R8 no rearbitration", grant_o, 4'b0010);
        cpu_ack_i = 1'b0; #1;
        check("R5 drop with ack", grant_o, '0);
        @(negedge clk); req_i = '0; @(negedge clk);
    endtask

    task automatic t_empty();
        req_i = '0; cpu_ack_i = 1'b1;
        @(negedge clk);
        check("R6 empty ack", grant_o, '0);
        req_i = 4'b0001;
        @(negedge clk); @(negedge clk);
        check("R6 late request ignored", grant_o, '0);
        check("R1 irq during empty ack", {3'b0, irq_o}, 4'b0001);
        cpu_ack_i = 1'b0;
        @(negedge clk);
        req_i = '0;
        @(negedge clk);
    endtask

    task automatic t_rotate();
        set_mode(1'b1);
        serve("R4 rotate ptr0 1111", 4'b1111, 4'b0001);
        serve("R4 rotate ptr1 1111", 4'b1111, 4'b0010);
        serve("R4 rotate ptr2 1001", 4'b1001, 4'b1000);
        serve("R4 rotate wrap 1001", 4'b1001, 4'b0001);
        set_mode(1'b0);
        serve("R7 fixed mode again 1110", 4'b1110, 4'b0010);
        set_mode(1'b1);
        serve("R7 pointer kept 1101", 4'b1101, 4'b0100);
    endtask

    task automatic t_reset_ptr();
        do_reset();
        serve("R7 mode resets fixed 1010", 4'b1010, 4'b0010);
        set_mode(1'b1);
        serve("R4 pointer reset 1111", 4'b1111, 4'b0001);
    endtask

    initial begin
        do_reset();
        t_reset_irq();
        t_fixed();
        t_hold();
        t_empty();
        t_rotate();
        t_reset_ptr();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule